// File: doc/BRIEF.md
# Cross-VP Ring Transfer Network

This block carries single operands around a ring of virtual processors (VPs) that are interleaved over several lanes: VP i runs in lane i mod LANES. Each VP may send one value to its successor and take one value from its predecessor. The block does not decode instructions. Each lane presents a send channel and a receive channel, both with valid/ready handshakes. The block works out which VP a transfer belongs to by counting the completed transfers in that lane.

Between each lane and the next sits a small link buffer. The last active VP (index `vec_len-1`) sends into a wrap-around queue instead of a link, and VP0 receives from that queue. The control processor can push into the same queue to seed a chain and can pop from it to collect the final value. All transfers are paced by handshakes alone. A receive waits until its value exists, and a send waits while its buffer is full.

Top module: `crossvp_ring`

## Requirements
- R1: Lane l carries the transfers of VPs l, l+LANES, l+2·LANES, ... in increasing order. After the transfer of the highest such VP below `vec_len`, the lane returns to VP l. Send and receive sides keep separate positions.
- R2: A value sent by VP i with i < `vec_len-1` is delivered only to the receive of VP i+1, in send order.
- R3: The value sent by VP `vec_len-1` enters the wrap-around queue. A receive by VP0 and a control-processor pop take the oldest queue entry, shown on `rcv_data[0]` or `cp_pop_data`.
- R4: `rcv_valid` stays low until the matching value is buffered. A receive offer not taken holds its valid and data.
- R5: The wrap-around queue holds WQ_DEPTH (default 4) values. When it is full, a send by the last VP stalls and `cp_push_ready` is low. When it is empty, `cp_pop_ready` is low.
- R6: If the last VP offers a send in a cycle, the control-processor push is refused in that cycle. If VP0 is ready to receive from a non-empty queue, the control-processor pop is refused in that cycle.
- R7: A lane l with l ≥ `vec_len` never raises `snd_ready` or `rcv_valid`, whatever its inputs are.
- R8: After reset all buffers are empty, every `rcv_valid` and `cp_pop_ready` is low, `cp_push_ready` is high, and each lane's next VP on both sides is its lane index.
- R9: Each lane-to-lane link holds LINK_DEPTH (default 2) values. After that many unreceived sends, `snd_ready` of the sending lane drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vec_len | input | $clog2(NVP+1) | Active VP count. Change it only during reset |
| snd_valid | input | LANES | Per-lane send offer |
| snd_data | input | LANES×DW | Per-lane send operand |
| snd_ready | output | LANES | Per-lane send accepted |
| rcv_valid | output | LANES | Per-lane receive operand available |
| rcv_data | output | LANES×DW | Per-lane received operand |
| rcv_ready | input | LANES | Per-lane receive taken |
| cp_push_valid | input | 1 | Control-processor push offer |
| cp_push_data | input | DW | Control-processor push value |
| cp_push_ready | output | 1 | Push accepted |
| cp_pop_valid | input | 1 | Control-processor pop request |
| cp_pop_data | output | DW | Oldest wrap-around queue value |
| cp_pop_ready | output | 1 | Pop accepted |

## Verification
The bench builds the ring with four lanes, at most 16 VPs, 16-bit data, 2-entry links and a 4-entry wrap-around queue. A range of `vec_len` values is applied, with a reset before each change. Vector lengths of 0, 1, 3, 4, 11 and 16 cover several cases: idle lanes, a single VP that feeds itself through the queue, a last VP in the middle of the lanes, and several VPs per lane, including the link from the top lane back to lane 0. Stall-heavy traffic fills the links and the queue, and it makes the control-processor channels contend with lane traffic.

// File: rtl/crossvp_pkg.sv
package crossvp_pkg;
  typedef enum logic {
    SRC_LINK = 1'b0,
    SRC_WRAP = 1'b1
  } crossvp_src_e;
endpackage

// File: rtl/crossvp_fifo.sv
module crossvp_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          full,
  output logic          empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push) wr_d = (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (pop)  rd_d = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= push_data;
  end

  assign head  = mem[rd_q];
  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);

  // R9 / R5: the surrounding control never writes a full buffer
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt_q < CW'(DEPTH)));
  // R4: the surrounding control never reads an empty buffer
  a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt_q != '0));
endmodule

// File: rtl/crossvp_lane_seq.sv
module crossvp_lane_seq #(
  parameter int LANES = 4,
  parameter int LANE  = 0,
  parameter int IW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] vec_len,
  input  logic          snd_fire,
  input  logic          rcv_fire,
  output logic [IW-1:0] snd_idx,
  output logic [IW-1:0] rcv_idx
);
  logic [IW-1:0] snd_q, snd_d, rcv_q, rcv_d;

  function automatic logic [IW-1:0] step(input logic [IW-1:0] cur);
    logic [IW:0] sum;
    sum = {1'b0, cur} + (IW+1)'(LANES);
    if (sum >= {1'b0, vec_len}) return IW'(LANE);
    return sum[IW-1:0];
  endfunction

  always_comb begin
    snd_d = snd_fire ? step(snd_q) : snd_q;
    rcv_d = rcv_fire ? step(rcv_q) : rcv_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snd_q <= IW'(LANE);
      rcv_q <= IW'(LANE);
    end else begin
      snd_q <= snd_d;
      rcv_q <= rcv_d;
    end
  end

  assign snd_idx = snd_q;
  assign rcv_idx = rcv_q;

  // R1: a lane only ever serves VPs congruent to its own index
  a_r1_lane_owns_vp: assert property (@(posedge clk) disable iff (!rst_n)
    ((int'(snd_q) % LANES) == LANE) && ((int'(rcv_q) % LANES) == LANE));
endmodule

// File: rtl/crossvp_ring.sv
module crossvp_ring
  import crossvp_pkg::*;
#(
  parameter int LANES      = 4,
  parameter int NVP        = 32,
  parameter int DW         = 32,
  parameter int LINK_DEPTH = 2,
  parameter int WQ_DEPTH   = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [$clog2(NVP+1)-1:0]      vec_len,
  input  logic [LANES-1:0]              snd_valid,
  input  logic [LANES-1:0][DW-1:0]      snd_data,
  output logic [LANES-1:0]              snd_ready,
  output logic [LANES-1:0]              rcv_valid,
  output logic [LANES-1:0][DW-1:0]      rcv_data,
  input  logic [LANES-1:0]              rcv_ready,
  input  logic                          cp_push_valid,
  input  logic [DW-1:0]                 cp_push_data,
  output logic                          cp_push_ready,
  input  logic                          cp_pop_valid,
  output logic [DW-1:0]                 cp_pop_data,
  output logic                          cp_pop_ready
);
  localparam int IW = $clog2(NVP + 1);

  logic [LANES-1:0][IW-1:0] s_idx, r_idx;
  logic [LANES-1:0]         s_act, s_wrap, r_act;
  crossvp_src_e             r_src [LANES];
  logic [LANES-1:0]         s_fire, r_fire;
  logic [LANES-1:0]         lk_push, lk_pop, lk_full, lk_empty;
  logic [LANES-1:0][DW-1:0] lk_head;

  logic          wq_push, wq_pop, wq_full, wq_empty;
  logic [DW-1:0] wq_wdata, wq_head, lane_wq_data;
  logic          lane_wq_req, lane_wq_fire, vp0_pull;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam int PRV = (l + LANES - 1) % LANES;
    localparam int NXT = (l + 1) % LANES;

    crossvp_lane_seq #(.LANES(LANES), .LANE(l), .IW(IW)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .vec_len  (vec_len),
      .snd_fire (s_fire[l]),
      .rcv_fire (r_fire[l]),
      .snd_idx  (s_idx[l]),
      .rcv_idx  (r_idx[l])
    );

    assign s_act[l]  = (s_idx[l] < vec_len);
    assign s_wrap[l] = s_act[l] && (s_idx[l] == vec_len - 1'b1);
    assign r_act[l]  = (r_idx[l] < vec_len);
    assign r_src[l]  = (r_act[l] && (r_idx[l] == '0)) ? SRC_WRAP : SRC_LINK;

    assign snd_ready[l] = s_act[l] && (s_wrap[l] ? !wq_full : !lk_full[l]);
    assign s_fire[l]    = snd_valid[l] && snd_ready[l];

    assign rcv_valid[l] = r_act[l] &&
                          ((r_src[l] == SRC_WRAP) ? !wq_empty : !lk_empty[PRV]);
    assign rcv_data[l]  = (r_src[l] == SRC_WRAP) ? wq_head : lk_head[PRV];
    assign r_fire[l]    = rcv_valid[l] && rcv_ready[l];

    // link from lane l to the lane of the successor VP
    assign lk_push[l] = s_fire[l] && !s_wrap[l];
    assign lk_pop[l]  = r_fire[NXT] && (r_src[NXT] == SRC_LINK);

    crossvp_fifo #(.DW(DW), .DEPTH(LINK_DEPTH)) u_link (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (lk_push[l]),
      .push_data (snd_data[l]),
      .pop       (lk_pop[l]),
      .head      (lk_head[l]),
      .full      (lk_full[l]),
      .empty     (lk_empty[l])
    );

    // R4: an untaken receive from a link keeps its value
    a_r4_rcv_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (rcv_valid[l] && !rcv_ready[l] && (r_src[l] == SRC_LINK))
        |=> (rcv_valid[l] && $stable(rcv_data[l])));
    // R7: lanes without VPs stay silent
    a_r7_idle_lane: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(vec_len) <= l) |-> (!snd_ready[l] && !rcv_valid[l]));
  end

  // wrap-around queue write side: last VP first, then control processor
  always_comb begin
    lane_wq_data = '0;
    for (int l = 0; l < LANES; l++) begin
      if (s_wrap[l]) lane_wq_data = lane_wq_data | snd_data[l];
    end
  end

  assign lane_wq_req   = |(snd_valid & s_wrap);
  assign lane_wq_fire  = |(s_fire & s_wrap);
  assign cp_push_ready = !wq_full && !lane_wq_req;
  assign wq_push       = lane_wq_fire || (cp_push_valid && cp_push_ready);
  assign wq_wdata      = lane_wq_fire ? lane_wq_data : cp_push_data;

  // read side: VP0 first, then control processor
  assign vp0_pull     = rcv_ready[0] && (r_src[0] == SRC_WRAP);
  assign cp_pop_ready = !wq_empty && !vp0_pull;
  assign cp_pop_data  = wq_head;
  assign wq_pop       = (vp0_pull && !wq_empty) || (cp_pop_valid && cp_pop_ready);

  crossvp_fifo #(.DW(DW), .DEPTH(WQ_DEPTH)) u_wrapq (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (wq_push),
    .push_data (wq_wdata),
    .pop       (wq_pop),
    .head      (wq_head),
    .full      (wq_full),
    .empty     (wq_empty)
  );

  // R3: at most one lane can be the last VP's sender in any cycle
  a_r3_single_wrap_sender: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(s_fire & s_wrap));
  // R6: a lane send into the queue and a control push never coincide
  a_r6_push_yields: assert property (@(posedge clk) disable iff (!rst_n)
    lane_wq_fire |-> !(cp_push_valid && cp_push_ready));
endmodule

// File: tb/tb_crossvp_ring.sv
module tb_crossvp_ring;
  localparam int L   = 4;
  localparam int NVP = 16;
  localparam int DW  = 16;
  localparam int LKD = 2;
  localparam int WQD = 4;
  localparam int IW  = $clog2(NVP + 1);

  logic                  clk = 1'b0;
  logic                  rst_n;
  logic [IW-1:0]         vec_len;
  logic [L-1:0]          snd_valid, snd_ready, rcv_valid, rcv_ready;
  logic [L-1:0][DW-1:0]  snd_data, rcv_data;
  logic                  cp_push_valid, cp_push_ready, cp_pop_valid, cp_pop_ready;
  logic [DW-1:0]         cp_push_data, cp_pop_data;

  crossvp_ring #(.LANES(L), .NVP(NVP), .DW(DW), .LINK_DEPTH(LKD), .WQ_DEPTH(WQD)) dut (
    .clk(clk), .rst_n(rst_n), .vec_len(vec_len),
    .snd_valid(snd_valid), .snd_data(snd_data), .snd_ready(snd_ready),
    .rcv_valid(rcv_valid), .rcv_data(rcv_data), .rcv_ready(rcv_ready),
    .cp_push_valid(cp_push_valid), .cp_push_data(cp_push_data), .cp_push_ready(cp_push_ready),
    .cp_pop_valid(cp_pop_valid), .cp_pop_data(cp_pop_data), .cp_pop_ready(cp_pop_ready)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  // behavioural model state
  int            sidx [L];
  int            ridx [L];
  logic [DW-1:0] lq [L][$];
  logic [DW-1:0] wq [$];
  logic [L-1:0]  pend;
  logic [DW-1:0] pdata [L];
  logic          cp_pend;
  logic [DW-1:0] cp_pdata;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int adv(input int idx, input int lane, input int vl);
    int n;
    n = idx + L;
    return (n >= vl) ? lane : n;
  endfunction

  task automatic reset_to(input int vl);
    @(negedge clk);
    rst_n = 1'b0;
    vec_len = IW'(vl);
    snd_valid = '0; rcv_ready = '0; snd_data = '0;
    cp_push_valid = 1'b0; cp_pop_valid = 1'b0; cp_push_data = '0;
    pend = '0; cp_pend = 1'b0;
    for (int l = 0; l < L; l++) begin
      sidx[l] = l; ridx[l] = l; lq[l].delete();
    end
    wq.delete();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R8: reset state at the ports
    chk(rcv_valid == '0, "R8", "rcv_valid after reset", rcv_valid, 0);
    chk(cp_pop_ready == 1'b0, "R8", "cp_pop_ready after reset", cp_pop_ready, 0);
    chk(cp_push_ready == 1'b1, "R8", "cp_push_ready after reset", cp_push_ready, 1);
  endtask

  task automatic run_phase(input int vl, input int n, input int p_snd, input int p_rcv,
                           input int p_push, input int p_pop);
    bit e_sr [L]; bit e_rv [L]; bit s_wr [L]; bit r_wq [L];
    bit wreq, e_push_rdy, e_pop_rdy;
    logic [DW-1:0] e_rd;
    reset_to(vl);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      for (int l = 0; l < L; l++) begin
        if (!pend[l] && ($urandom_range(99) < p_snd)) begin
          pend[l] = 1'b1; pdata[l] = DW'($urandom);
        end
        snd_valid[l] = pend[l];
        snd_data[l]  = pend[l] ? pdata[l] : '0;
        rcv_ready[l] = ($urandom_range(99) < p_rcv);
      end
      if (!cp_pend && ($urandom_range(99) < p_push)) begin
        cp_pend = 1'b1; cp_pdata = DW'($urandom);
      end
      cp_push_valid = cp_pend;
      cp_push_data  = cp_pdata;
      cp_pop_valid  = ($urandom_range(99) < p_pop);
      #1;
      wreq = 1'b0;
      for (int l = 0; l < L; l++) begin
        int prv;
        bit sa, ra;
        prv = (l + L - 1) % L;
        sa = sidx[l] < vl;
        s_wr[l] = sa && (sidx[l] == vl - 1);
        e_sr[l] = sa && (s_wr[l] ? (wq.size() < WQD) : (lq[l].size() < LKD));
        ra = ridx[l] < vl;
        r_wq[l] = ra && (ridx[l] == 0);
        e_rv[l] = ra && (r_wq[l] ? (wq.size() > 0) : (lq[prv].size() > 0));
        if (snd_valid[l] && s_wr[l]) wreq = 1'b1;
        if (!sa)
          chk(snd_ready[l] == e_sr[l], "R7", $sformatf("lane %0d snd_ready idle", l), snd_ready[l], e_sr[l]);
        else if (s_wr[l])
          chk(snd_ready[l] == e_sr[l], "R5", $sformatf("lane %0d snd_ready to queue", l), snd_ready[l], e_sr[l]);
        else
          chk(snd_ready[l] == e_sr[l], "R9", $sformatf("lane %0d snd_ready to link", l), snd_ready[l], e_sr[l]);
        if (!ra)
          chk(rcv_valid[l] == e_rv[l], "R7", $sformatf("lane %0d rcv_valid idle", l), rcv_valid[l], e_rv[l]);
        else
          chk(rcv_valid[l] == e_rv[l], "R4", $sformatf("lane %0d rcv_valid", l), rcv_valid[l], e_rv[l]);
        if (e_rv[l]) begin
          e_rd = r_wq[l] ? wq[0] : lq[prv][0];
          if (r_wq[l])
            chk(rcv_data[l] == e_rd, "R3", $sformatf("lane %0d data from queue", l), rcv_data[l], e_rd);
          else
            chk(rcv_data[l] == e_rd, "R2", $sformatf("lane %0d data from VP %0d", l, ridx[l] - 1), rcv_data[l], e_rd);
        end
      end
      e_push_rdy = (wq.size() < WQD) && !wreq;
      e_pop_rdy  = (wq.size() > 0) && !(rcv_ready[0] && r_wq[0]);
      chk(cp_push_ready == e_push_rdy, "R6", "cp_push_ready", cp_push_ready, e_push_rdy);
      chk(cp_pop_ready == e_pop_rdy, "R6", "cp_pop_ready", cp_pop_ready, e_pop_rdy);
      if (e_pop_rdy)
        chk(cp_pop_data == wq[0], "R3", "cp_pop_data", cp_pop_data, wq[0]);
      // model update: reads first, then writes, then positions (R1)
      for (int l = 0; l < L; l++) begin
        if (rcv_ready[l] && e_rv[l]) begin
          if (r_wq[l]) void'(wq.pop_front());
          else void'(lq[(l + L - 1) % L].pop_front());
          ridx[l] = adv(ridx[l], l, vl);
        end
      end
      if (cp_pop_valid && e_pop_rdy) void'(wq.pop_front());
      for (int l = 0; l < L; l++) begin
        if (snd_valid[l] && e_sr[l]) begin
          if (s_wr[l]) wq.push_back(pdata[l]);
          else lq[l].push_back(pdata[l]);
          sidx[l] = adv(sidx[l], l, vl);
          pend[l] = 1'b0;
        end
      end
      if (cp_push_valid && e_push_rdy) begin
        wq.push_back(cp_pdata);
        cp_pend = 1'b0;
      end
    end
  endtask

  initial begin
    rst_n = 1'b0;
    vec_len = '0;
    snd_valid = '0; rcv_ready = '0; snd_data = '0;
    cp_push_valid = 1'b0; cp_pop_valid = 1'b0; cp_push_data = '0;
    run_phase(4, 2000, 60, 60, 30, 30);   // one VP per lane (R1, R2)
    run_phase(3, 2000, 60, 60, 30, 30);   // lane 3 idle (R7)
    run_phase(11, 2500, 70, 25, 20, 15);  // stalls fill links (R9, R4)
    run_phase(1, 1500, 60, 50, 50, 40);   // VP0 feeds itself (R3, R6)
    run_phase(0, 500, 60, 60, 50, 50);    // no VPs, queue only (R5, R7)
    run_phase(16, 2500, 60, 60, 25, 25);  // full ring (R1, R2)
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule